// File: doc/BRIEF.md
# Watchdog and Supply Reset Supervisor

This block produces the system reset for a microcontroller. One reset stretcher is shared by three reset sources. The first is the release of the power-on reset. The second is a low-supply flag from an external comparator. The third is a watchdog timer. Whenever any source fires, reset is asserted. Reset is then held for a fixed stretch, counted in 1 ms tick strobes, and the stretch only starts once the source has gone away. Reset is driven on two outputs, one active high and one active low.

Firmware keeps the watchdog from firing by pulsing the active-low kick input, which is normally a chip select. A pulse counts only if it stays low long enough. A short glitch does not restart the count. A 2-bit register sets the watchdog interval or switches the watchdog off. A volatile flag records whether the last reset came from the watchdog or from low supply, and firmware can clear it.

Top module: `supv_top`

## Requirements
- R1: After the power-on reset `rst_n` is released, `sys_rst` stays high for STRETCH_TICKS (200) tick strobes and then falls.
- R2: While `supply_ok` is low, `sys_rst` is high. After `supply_ok` returns high, `sys_rst` stays high for a further 200 tick strobes.
- R3: If no kick arrives, the watchdog expires the following number of ticks after reset is released, depending on the select code: code 2'b10 gives 200 ticks, 2'b01 gives 600 ticks and 2'b00 gives 1400 ticks.
- R4: When the watchdog expires, `sys_rst` is asserted for 200 tick strobes.
- R5: A low pulse on `kick_n` that lasts at least KICK_MIN_CLK (40) clock cycles restarts the watchdog count from zero. A shorter pulse has no effect.
- R6: Select code 2'b11 disables the watchdog, so no watchdog reset is ever raised.
- R7: `tosel_q` reads back the select code. It changes only in a cycle where `tosel_wr` is high. Its value after power-on is 2'b00. Supply resets and watchdog resets leave it unchanged.
- R8: `cause_wd` is 0 after power-on. It becomes 1 when a watchdog reset is raised and becomes 0 when a low-supply reset is raised. A pulse on `cause_clr` sets it to 0.
- R9: Low supply takes priority. If the supply drops during a watchdog stretch, `cause_wd` reads 0, and the full 200-tick stretch is counted from the moment the supply recovers.
- R10: `sys_rst_n` is always the complement of `sys_rst`.
- R11: The watchdog count is held at zero while reset is asserted and starts from zero when reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| tick_1ms | input | 1 | One-cycle strobe, once per millisecond |
| supply_ok | input | 1 | Comparator flag, high when the supply is good (asynchronous) |
| kick_n | input | 1 | Watchdog kick / chip select, active low (asynchronous) |
| tosel_wr | input | 1 | Write strobe for the timeout select |
| tosel_wdata | input | 2 | New timeout select code |
| tosel_q | output | 2 | Current timeout select code |
| cause_clr | input | 1 | Clears the reset-cause flag |
| cause_wd | output | 1 | 1 means the last reset came from the watchdog, 0 means from low supply |
| sys_rst | output | 1 | System reset, active high |
| sys_rst_n | output | 1 | System reset, active low |

## Verification
The case that needs care is a supply drop arriving while the stretcher is already timing a watchdog reset. Both sources then write to the same stretch counter and to the same cause flag. The bench waits for a watchdog reset to begin. Partway through that stretch it pulls `supply_ok` low. It then checks that `cause_wd` reads 0 and that reset stays asserted for the whole low period. Finally it counts tick strobes from the moment the supply recovers, and expects a full stretch rather than whatever remained of the watchdog stretch.

// File: rtl/supv_pkg.sv
package supv_pkg;

  typedef enum logic [1:0] {
    SEL_LONG  = 2'b00,
    SEL_MID   = 2'b01,
    SEL_SHORT = 2'b10,
    SEL_OFF   = 2'b11
  } wd_sel_e;

  // Timeout in ticks for a select code; 0 means the watchdog is off.
  function automatic int unsigned sel_to_ticks(input logic [1:0] sel,
                                               input int unsigned t_short,
                                               input int unsigned t_mid,
                                               input int unsigned t_long);
    case (wd_sel_e'(sel))
      SEL_SHORT: return t_short;
      SEL_MID:   return t_mid;
      SEL_LONG:  return t_long;
      default:   return 0;
    endcase
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int unsigned W       = 1,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= {W{RST_VAL}};
      q    <= {W{RST_VAL}};
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/supv_kick_qual.sv
module supv_kick_qual #(
  parameter int unsigned MIN_CLK = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_n_s,
  output logic kick_ok
);
  localparam int unsigned CW = $clog2(MIN_CLK + 1);

  logic          prev_n;
  logic [CW-1:0] low_cnt;
  logic          kick_fall;

  assign kick_fall = prev_n && !kick_n_s;
  assign kick_ok   = !kick_n_s && (low_cnt == CW'(MIN_CLK - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_n  <= 1'b1;
      low_cnt <= '0;
    end else begin
      prev_n <= kick_n_s;
      if (kick_fall)
        low_cnt <= CW'(1);
      else if (kick_n_s)
        low_cnt <= '0;
      else if (low_cnt != CW'(MIN_CLK))
        low_cnt <= low_cnt + CW'(1);
    end
  end

  // One restart per low pulse
  assert_single_kick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    kick_ok |=> !kick_ok);
endmodule

// File: rtl/supv_wdog.sv
module supv_wdog
  import supv_pkg::*;
#(
  parameter int unsigned T_SHORT = 200,
  parameter int unsigned T_MID   = 600,
  parameter int unsigned T_LONG  = 1400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] sel,
  input  logic       hold,
  input  logic       kick_ok,
  output logic       expire
);
  localparam int unsigned TMAX = max3(T_SHORT, T_MID, T_LONG);
  localparam int unsigned CW   = $clog2(TMAX + 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          enabled;

  always_comb begin
    lim     = CW'(sel_to_ticks(sel, T_SHORT, T_MID, T_LONG));
    enabled = (lim != '0);
  end

  // >= keeps expiry working when a smaller limit is written mid-count
  assign expire = tick && enabled && !hold && !kick_ok && (cnt >= lim - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (hold || kick_ok || expire)
      cnt <= '0;
    else if (tick && enabled)
      cnt <= cnt + CW'(1);
  end

  assert_hold_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (cnt == '0));
  assert_kick_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (kick_ok && !hold) |=> (cnt == '0));
  assert_off_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 2'b11) |-> !expire);
endmodule

// File: rtl/supv_rst_core.sv
module supv_rst_core #(
  parameter int unsigned STRETCH = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic supply_ok_s,
  input  logic wd_expire,
  input  logic cause_clr,
  output logic rst_q,
  output logic cause_wd
);
  localparam int unsigned CW = $clog2(STRETCH + 1);

  logic [CW-1:0] st_cnt;
  logic          st_done;

  assign st_done = tick && (st_cnt == CW'(STRETCH - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_q  <= 1'b1;
      st_cnt <= '0;
    end else if (!supply_ok_s || wd_expire) begin
      rst_q  <= 1'b1;
      st_cnt <= '0;
    end else if (rst_q && tick) begin
      if (st_done) begin
        rst_q  <= 1'b0;
        st_cnt <= '0;
      end else begin
        st_cnt <= st_cnt + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cause_wd <= 1'b0;
    else if (!supply_ok_s)
      cause_wd <= 1'b0;
    else if (wd_expire)
      cause_wd <= 1'b1;
    else if (cause_clr)
      cause_wd <= 1'b0;
  end

  assert_low_supply_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok_s |=> rst_q);
  assert_wd_asserts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wd_expire |=> rst_q);
  assert_cause_wd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_expire && supply_ok_s) |=> cause_wd);
  assert_supply_prio_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok_s |=> !cause_wd);
endmodule

// File: rtl/supv_top.sv
module supv_top #(
  parameter int unsigned STRETCH_TICKS = 200,
  parameter int unsigned WD_SHORT      = 200,
  parameter int unsigned WD_MID        = 600,
  parameter int unsigned WD_LONG       = 1400,
  parameter int unsigned KICK_MIN_CLK  = 40,
  parameter logic [1:0]  TOSEL_RST     = 2'b00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_1ms,
  input  logic       supply_ok,
  input  logic       kick_n,
  input  logic       tosel_wr,
  input  logic [1:0] tosel_wdata,
  output logic [1:0] tosel_q,
  input  logic       cause_clr,
  output logic       cause_wd,
  output logic       sys_rst,
  output logic       sys_rst_n
);
  logic supply_ok_s;
  logic kick_n_s;
  logic kick_ok;
  logic wd_expire;
  logic rst_q;

  supv_sync #(.W(1), .RST_VAL(1'b0)) u_sync_sup (
    .clk(clk), .rst_n(rst_n), .d(supply_ok), .q(supply_ok_s));

  supv_sync #(.W(1), .RST_VAL(1'b1)) u_sync_kick (
    .clk(clk), .rst_n(rst_n), .d(kick_n), .q(kick_n_s));

  supv_kick_qual #(.MIN_CLK(KICK_MIN_CLK)) u_kick (
    .clk(clk), .rst_n(rst_n), .kick_n_s(kick_n_s), .kick_ok(kick_ok));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      tosel_q <= TOSEL_RST;
    else if (tosel_wr)
      tosel_q <= tosel_wdata;
  end

  supv_wdog #(.T_SHORT(WD_SHORT), .T_MID(WD_MID), .T_LONG(WD_LONG)) u_wdog (
    .clk(clk), .rst_n(rst_n), .tick(tick_1ms), .sel(tosel_q),
    .hold(rst_q), .kick_ok(kick_ok), .expire(wd_expire));

  supv_rst_core #(.STRETCH(STRETCH_TICKS)) u_core (
    .clk(clk), .rst_n(rst_n), .tick(tick_1ms), .supply_ok_s(supply_ok_s),
    .wd_expire(wd_expire), .cause_clr(cause_clr),
    .rst_q(rst_q), .cause_wd(cause_wd));

  assign sys_rst   = rst_q;
  assign sys_rst_n = ~rst_q;

  assert_sel_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tosel_wr |=> $stable(tosel_q));
endmodule

// File: tb/sim_supv_top.sv
module sim_supv_top;
  localparam int TICKP    = 4;
  localparam int KMIN     = 40;
  localparam int STRETCH  = 200;
  localparam int WDOG_CYC = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_1ms = 1'b0;
  logic supply_ok = 1'b1;
  logic kick_n = 1'b1;
  logic tosel_wr = 1'b0;
  logic [1:0] tosel_wdata = 2'b00;
  logic [1:0] tosel_q;
  logic cause_clr = 1'b0;
  logic cause_wd;
  logic sys_rst;
  logic sys_rst_n;

  int total = 0;
  int bad = 0;
  int pol_err = 0;
  int rises = 0;
  bit done = 1'b0;
  logic prev_rst = 1'b1;

  supv_top u0 (
    .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms), .supply_ok(supply_ok),
    .kick_n(kick_n), .tosel_wr(tosel_wr), .tosel_wdata(tosel_wdata),
    .tosel_q(tosel_q), .cause_clr(cause_clr), .cause_wd(cause_wd),
    .sys_rst(sys_rst), .sys_rst_n(sys_rst_n));

  always #5 clk = ~clk;

  initial begin
    int ph;
    ph = 0;
    forever begin
      @(posedge clk); #1;
      tick_1ms = (ph == TICKP - 1);
      ph = (ph == TICKP - 1) ? 0 : ph + 1;
    end
  end

  always @(negedge clk) begin
    if (sys_rst_n !== ~sys_rst) pol_err++;
    if (sys_rst === 1'b1 && prev_rst === 1'b0) rises++;
    prev_rst = sys_rst;
  end

  function automatic int exp_ticks(input logic [1:0] s);
    if (s == 2'b10) return 200;
    if (s == 2'b01) return 600;
    if (s == 2'b00) return 1400;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic write_sel(input logic [1:0] v);
    tosel_wdata = v; tosel_wr = 1'b1;
    cyc(1);
    tosel_wr = 1'b0;
  endtask

  task automatic kick(input int w);
    kick_n = 1'b0;
    cyc(w);
    kick_n = 1'b1;
  endtask

  // count tick strobes until sys_rst reaches lvl (or maxt exceeded)
  task automatic ticks_until(input logic lvl, input int maxt, output int nt, output bit hit);
    nt = 0; hit = 1'b0;
    forever begin
      @(negedge clk);
      if (sys_rst === lvl) begin hit = 1'b1; break; end
      if (tick_1ms) nt++;
      if (nt > maxt) break;
    end
  endtask

  task automatic report;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (WDOG_CYC) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired act=0 exp=1");
      report();
    end
  end

  initial begin
    int nt, r0, lim;
    bit hit;
    void'($urandom(32'd4242));

    // Reset state
    cyc(3);
    @(negedge clk);
    chk(sys_rst === 1'b1 && sys_rst_n === 1'b0, "R10 reset state polarity", sys_rst, 1);
    chk(tosel_q === 2'b00, "R7 select power-on value", tosel_q, 0);
    chk(cause_wd === 1'b0, "R8 cause power-on value", cause_wd, 0);

    // R1 power-on stretch
    cyc(1);
    rst_n = 1'b1;
    ticks_until(1'b0, 400, nt, hit);
    chk(hit && nt >= STRETCH && nt <= STRETCH + 1, "R1 power-on stretch ticks", nt, STRETCH);

    // R3/R11 short timeout from release
    fork
      write_sel(2'b10);
      ticks_until(1'b1, 2000, nt, hit);
    join
    chk(hit && nt >= 200 && nt <= 201, "R3 R11 timeout code 10", nt, exp_ticks(2'b10));
    @(negedge clk);
    chk(cause_wd === 1'b1, "R8 cause after watchdog", cause_wd, 1);

    // R4 watchdog stretch, select changed while in reset
    fork
      write_sel(2'b01);
      ticks_until(1'b0, 400, nt, hit);
    join
    chk(hit && nt >= STRETCH && nt <= STRETCH + 1, "R4 watchdog reset length", nt, STRETCH);
    ticks_until(1'b1, 2000, nt, hit);
    chk(hit && nt >= 600 && nt <= 601, "R3 timeout code 01", nt, exp_ticks(2'b01));

    // clear cause during stretch
    fork
      begin
        write_sel(2'b00);
        cyc(20);
        cause_clr = 1'b1; cyc(1); cause_clr = 1'b0;
        @(negedge clk);
        chk(cause_wd === 1'b0, "R8 cause cleared", cause_wd, 0);
      end
      ticks_until(1'b0, 400, nt, hit);
    join
    chk(hit && nt >= STRETCH && nt <= STRETCH + 1, "R4 watchdog reset length 2", nt, STRETCH);
    ticks_until(1'b1, 2000, nt, hit);
    chk(hit && nt >= 1400 && nt <= 1401, "R3 timeout code 00", nt, exp_ticks(2'b00));

    // R9 supply drop during watchdog stretch
    write_sel(2'b10);
    cyc(100 * TICKP);
    supply_ok = 1'b0;
    cyc(4);
    @(negedge clk);
    chk(sys_rst === 1'b1, "R9 reset held on supply drop", sys_rst, 1);
    chk(cause_wd === 1'b0, "R9 cause set to low supply", cause_wd, 0);
    cyc(50 * TICKP);
    @(negedge clk);
    chk(sys_rst === 1'b1, "R2 reset held while supply low", sys_rst, 1);
    cyc(1);
    fork
      supply_ok = 1'b1;
      ticks_until(1'b0, 400, nt, hit);
    join
    chk(hit && nt >= STRETCH && nt <= STRETCH + 1, "R9 R2 full stretch after recovery", nt, STRETCH);
    chk(tosel_q === 2'b10, "R7 select kept across resets", tosel_q, 2);

    // R6 watchdog off
    fork
      write_sel(2'b11);
      ticks_until(1'b1, 1600, nt, hit);
    join
    chk(!hit, "R6 no reset when disabled", hit, 0);

    // R2 standalone low supply
    cyc(1);
    supply_ok = 1'b0;
    cyc(3);
    @(negedge clk);
    chk(sys_rst === 1'b1, "R2 reset on supply low", sys_rst, 1);
    cyc(500);
    @(negedge clk);
    chk(sys_rst === 1'b1 && cause_wd === 1'b0, "R2 R8 still low supply", sys_rst, 1);
    chk(tosel_q === 2'b11, "R7 select kept after supply reset", tosel_q, 3);
    cyc(1);
    fork
      supply_ok = 1'b1;
      ticks_until(1'b0, 400, nt, hit);
    join
    chk(hit && nt >= STRETCH && nt <= STRETCH + 1, "R2 stretch after recovery", nt, STRETCH);

    // R5 short kicks ignored
    fork
      begin
        write_sel(2'b10);
        for (int k = 0; k < 3; k++) begin
          cyc(50 * TICKP);
          kick(KMIN - 8);
        end
      end
      ticks_until(1'b1, 2000, nt, hit);
    join
    chk(hit && nt >= 200 && nt <= 201, "R5 short kicks ignored", nt, 200);
    ticks_until(1'b0, 400, nt, hit);
    chk(hit && nt >= STRETCH && nt <= STRETCH + 1, "R4 stretch after timeout", nt, STRETCH);

    // R5 random valid kicks keep reset away
    r0 = rises;
    for (int k = 0; k < 12; k++) begin
      logic [1:0] s;
      s = ($urandom % 2 == 0) ? 2'b10 : 2'b01;
      write_sel(s);
      cyc(TICKP * (30 + int'($urandom % 120)));
      kick(KMIN + int'($urandom % 20));
    end
    write_sel(2'b10);
    @(negedge clk);
    chk(rises == r0 && sys_rst === 1'b0, "R5 valid kicks prevent reset", rises - r0, 0);

    // R5 final kick then timeout measured from pulse end
    cyc(10 * TICKP);
    kick(KMIN + 2);
    lim = exp_ticks(2'b10);
    ticks_until(1'b1, 2000, nt, hit);
    chk(hit && nt >= lim - 1 && nt <= lim + 1, "R5 R3 count restarts at kick", nt, lim);
    @(negedge clk);
    chk(cause_wd === 1'b1, "R8 cause after final watchdog", cause_wd, 1);

    chk(pol_err == 0, "R10 outputs complementary", pol_err, 0);
    done = 1'b1;
    report();
  end
endmodule